// File: doc/BRIEF.md
# Toggle and Fault Coverage Monitor

This block observes a vector of internal circuit nodes during a test run and keeps sticky activity flags for every node. Two toggle definitions are tracked at the same time. In level mode a node is covered once it has been sampled both low and high. In edge mode it is covered once both a rising and a falling change have been seen between consecutive samples. A mode input selects which definition drives the reported count. A clear input restarts the run.

On a start request the block takes a snapshot of the covered-node count and of externally supplied fault counts (detected, potentially detected, undetectable, total). It then computes three unsigned Q0.16 ratios in turn on one shared sequential divider: toggle coverage, modified fault coverage with a weighted credit for potential detects, and fault efficiency over the detectable faults. A one-cycle done pulse marks fresh results. A zero denominator forces the affected ratio to zero and raises an error flag.

Top module: `cov_monitor`

## Requirements
- R1: In level mode (edge_mode_i = 0), a node is counted in covered_o once it has been sampled (sample_i = 1) at 0 and, in any order, at 1.
- R2: In edge mode (edge_mode_i = 1), a node is counted only after a 0-to-1 and a 1-to-0 change between consecutive samples. The first sample after reset or clear only loads the history and records no change.
- R3: clear_i = 1 empties all flags and the history in the same cycle, taking priority over a simultaneous sample. After reset covered_o is 0.
- R4: While sample_i = 0, node values have no effect on covered_o.
- R5: toggle_cov_o = min(floor(C·65536 / NODES), 65535), where C is covered_o at start. Full coverage reads 16'hFFFF.
- R6: mod_cov_o = min(floor((D·65536 + W·P) / T), 65535), with W = WEIGHT_Q16 (default 32768, one half), D = det_i, P = pot_i, T = total_i.
- R7: fault_eff_o = min(floor(D·65536 / (T − U)), 65535), with U = undet_i.
- R8: If T = 0, mod_cov_o is 0. If T ≤ U, fault_eff_o is 0. In either case err_o is 1 with the results.
- R9: done_o is a one-cycle pulse that follows a busy period. The ratio outputs and err_o change only with done_o and hold afterwards. start_i is ignored while busy_o = 1.
- R10: node_total_o equals NODES at all times, and covered_o never exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe for nodes_i |
| clear_i | input | 1 | Restart the run: empty flags and history |
| edge_mode_i | input | 1 | 0: level toggle definition, 1: edge toggle definition |
| nodes_i | input | NODES | Observed node values |
| start_i | input | 1 | Request a ratio computation |
| det_i | input | CW | Detected fault count |
| pot_i | input | CW | Potentially detected fault count |
| undet_i | input | CW | Undetectable fault count |
| total_i | input | CW | Total fault count |
| covered_o | output | $clog2(NODES+1) | Covered nodes under the selected definition |
| node_total_o | output | $clog2(NODES+1) | Number of observed nodes |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| err_o | output | 1 | A denominator was zero in the last computation |
| toggle_cov_o | output | 16 | Toggle coverage, Q0.16 |
| mod_cov_o | output | 16 | Modified fault coverage, Q0.16 |
| fault_eff_o | output | 16 | Fault efficiency, Q0.16 |

## Verification
A corrupted per-node flag or history bit shows up in covered_o on the next negative clock edge after the sample that should have set it. The count is combinational on the flag registers, so the bench compares it against a behavioural model on every clock, in both modes and across clears. Divider or sequencing faults do not show until done_o. At that point all three ratios and err_o are compared to integer arithmetic computed in the bench, including saturation, zero-denominator and start-while-busy cases.

// File: rtl/cov_pkg.sv
package cov_pkg;
  localparam int unsigned FRAC_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_FINISH
  } ctl_state_e;

  typedef enum logic [1:0] {
    JOB_TOGGLE,
    JOB_MODCOV,
    JOB_EFF
  } job_e;
endpackage

// File: rtl/cov_node_track.sv
module cov_node_track #(
  parameter int unsigned NODES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             clear_i,
  input  logic             edge_mode_i,
  input  logic [NODES-1:0] nodes_i,
  output logic [NODES-1:0] cov_o
);
  // history valid: first sample after clear only loads prev
  logic hist_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hist_vld_q <= 1'b0;
    else if (clear_i)  hist_vld_q <= 1'b0;
    else if (sample_i) hist_vld_q <= 1'b1;
  end

  for (genvar g = 0; g < NODES; g++) begin : g_node
    logic lo_q, hi_q, rise_q, fall_q, prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q   <= 1'b0;
        hi_q   <= 1'b0;
        rise_q <= 1'b0;
        fall_q <= 1'b0;
        prev_q <= 1'b0;
      end else if (clear_i) begin
        lo_q   <= 1'b0;
        hi_q   <= 1'b0;
        rise_q <= 1'b0;
        fall_q <= 1'b0;
        prev_q <= 1'b0;
      end else if (sample_i) begin
        if (nodes_i[g]) hi_q <= 1'b1;
        else            lo_q <= 1'b1;
        if (hist_vld_q && !prev_q &&  nodes_i[g]) rise_q <= 1'b1;
        if (hist_vld_q &&  prev_q && !nodes_i[g]) fall_q <= 1'b1;
        prev_q <= nodes_i[g];
      end
    end

    assign cov_o[g] = edge_mode_i ? (rise_q & fall_q) : (lo_q & hi_q);
  end
endmodule

// File: rtl/cov_popcount.sv
module cov_popcount #(
  parameter int unsigned W   = 8,
  parameter int unsigned CNW = $clog2(W + 1)
) (
  input  logic [W-1:0]   vec_i,
  output logic [CNW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CNW'(vec_i[i]);
  end
endmodule

// File: rtl/cov_divider.sv
module cov_divider #(
  parameter int unsigned NW = 33,
  parameter int unsigned DW = 16,
  parameter int unsigned QW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          valid_o,
  output logic [QW-1:0] quo_o
);
  localparam int unsigned CNTW = $clog2(NW + 1);

  logic [NW-1:0]   num_q;  // dividend shifts out, quotient shifts in
  logic [DW-1:0]   den_q;
  logic [DW-1:0]   rem_q;
  logic [CNTW-1:0] cnt_q;
  logic            run_q;

  logic [DW:0]   rem_sh;
  logic [DW:0]   den_ext;
  logic          ge;
  logic [DW-1:0] rem_nx;

  always_comb begin
    rem_sh  = {rem_q, num_q[NW-1]};
    den_ext = {1'b0, den_q};
    ge      = rem_sh >= den_ext;
    rem_nx  = ge ? DW'(rem_sh - den_ext) : rem_sh[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q   <= '0;
      den_q   <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      valid_o <= 1'b0;
    end else if (start_i) begin
      num_q   <= num_i;
      den_q   <= den_i;
      rem_q   <= '0;
      cnt_q   <= CNTW'(NW);
      run_q   <= 1'b1;
      valid_o <= 1'b0;
    end else if (run_q) begin
      num_q <= {num_q[NW-2:0], ge};
      rem_q <= rem_nx;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) begin
        run_q   <= 1'b0;
        valid_o <= 1'b1;
      end else begin
        valid_o <= 1'b0;
      end
    end else begin
      valid_o <= 1'b0;
    end
  end

  // saturate results of 1.0 and above
  assign quo_o = (|num_q[NW-1:QW]) ? {QW{1'b1}} : num_q[QW-1:0];
endmodule

// File: rtl/cov_monitor.sv
module cov_monitor
  import cov_pkg::*;
#(
  parameter int unsigned NODES      = 8,
  parameter int unsigned CW         = 16,
  parameter int unsigned WEIGHT_Q16 = 32768,
  localparam int unsigned NCW       = $clog2(NODES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             clear_i,
  input  logic             edge_mode_i,
  input  logic [NODES-1:0] nodes_i,
  input  logic             start_i,
  input  logic [CW-1:0]    det_i,
  input  logic [CW-1:0]    pot_i,
  input  logic [CW-1:0]    undet_i,
  input  logic [CW-1:0]    total_i,
  output logic [NCW-1:0]   covered_o,
  output logic [NCW-1:0]   node_total_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [15:0]      toggle_cov_o,
  output logic [15:0]      mod_cov_o,
  output logic [15:0]      fault_eff_o
);
  localparam int unsigned NW = CW + FRAC_W + 1;

  logic [NODES-1:0] cov_vec;

  cov_node_track #(.NODES(NODES)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_i    (sample_i),
    .clear_i     (clear_i),
    .edge_mode_i (edge_mode_i),
    .nodes_i     (nodes_i),
    .cov_o       (cov_vec)
  );

  cov_popcount #(.W(NODES), .CNW(NCW)) u_count (
    .vec_i (cov_vec),
    .cnt_o (covered_o)
  );

  assign node_total_o = NCW'(NODES);

  ctl_state_e     state_q;
  job_e           job_q;
  logic [NCW-1:0] snap_cov_q;
  logic [CW-1:0]  det_q, pot_q, undet_q, total_q;
  logic [15:0]    stage_q [3];
  logic           err_stage_q;

  logic [NW-1:0]  div_num;
  logic [CW-1:0]  div_den;
  logic           den_bad;
  logic           div_start;
  logic           div_valid;
  logic [15:0]    div_quo;

  always_comb begin
    case (job_q)
      JOB_TOGGLE: begin
        div_num = NW'(snap_cov_q) << FRAC_W;
        div_den = CW'(NODES);
        den_bad = 1'b0;
      end
      JOB_MODCOV: begin
        div_num = (NW'(det_q) << FRAC_W) + NW'(WEIGHT_Q16) * NW'(pot_q);
        div_den = total_q;
        den_bad = (total_q == '0);
      end
      default: begin
        div_num = NW'(det_q) << FRAC_W;
        div_den = total_q - undet_q;
        den_bad = (total_q <= undet_q);
      end
    endcase
  end

  assign div_start = (state_q == ST_LAUNCH) && !den_bad;
  assign busy_o    = (state_q != ST_IDLE);

  cov_divider #(.NW(NW), .DW(CW), .QW(16)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (div_num),
    .den_i   (div_den),
    .valid_o (div_valid),
    .quo_o   (div_quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      job_q        <= JOB_TOGGLE;
      snap_cov_q   <= '0;
      det_q        <= '0;
      pot_q        <= '0;
      undet_q      <= '0;
      total_q      <= '0;
      err_stage_q  <= 1'b0;
      for (int i = 0; i < 3; i++) stage_q[i] <= '0;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
      toggle_cov_o <= '0;
      mod_cov_o    <= '0;
      fault_eff_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            snap_cov_q  <= covered_o;
            det_q       <= det_i;
            pot_q       <= pot_i;
            undet_q     <= undet_i;
            total_q     <= total_i;
            job_q       <= JOB_TOGGLE;
            err_stage_q <= 1'b0;
            state_q     <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          if (den_bad) begin
            stage_q[job_q] <= '0;
            err_stage_q    <= 1'b1;
            if (job_q == JOB_EFF) state_q <= ST_FINISH;
            else job_q <= job_e'(job_q + 2'd1);
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (div_valid) begin
            stage_q[job_q] <= div_quo;
            if (job_q == JOB_EFF) begin
              state_q <= ST_FINISH;
            end else begin
              job_q   <= job_e'(job_q + 2'd1);
              state_q <= ST_LAUNCH;
            end
          end
        end
        default: begin
          toggle_cov_o <= stage_q[0];
          mod_cov_o    <= stage_q[1];
          fault_eff_o  <= stage_q[2];
          err_o        <= err_stage_q;
          done_o       <= 1'b1;
          state_q      <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/cov_monitor_chk.sv
module cov_monitor_chk #(
  parameter int unsigned NODES = 8,
  localparam int unsigned NCW  = $clog2(NODES + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sample_i,
  input logic           clear_i,
  input logic           edge_mode_i,
  input logic [NCW-1:0] covered_o,
  input logic [NCW-1:0] node_total_o,
  input logic           busy_o,
  input logic           done_o,
  input logic           err_o,
  input logic [15:0]    toggle_cov_o,
  input logic [15:0]    mod_cov_o,
  input logic [15:0]    fault_eff_o
);
  p_clear_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> covered_o == '0);

  p_no_sample_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_i && !clear_i) |=> $stable(covered_o) || (edge_mode_i != $past(edge_mode_i)));

  p_sticky_grow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (covered_o >= $past(covered_o)) || (edge_mode_i != $past(edge_mode_i)));

  p_cov_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    covered_o <= node_total_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(toggle_cov_o) && $stable(mod_cov_o) && $stable(fault_eff_o) && $stable(err_o));

  p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (mod_cov_o == '0) || (fault_eff_o == '0));
endmodule

bind cov_monitor cov_monitor_chk #(.NODES(NODES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sample_i     (sample_i),
  .clear_i      (clear_i),
  .edge_mode_i  (edge_mode_i),
  .covered_o    (covered_o),
  .node_total_o (node_total_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .toggle_cov_o (toggle_cov_o),
  .mod_cov_o    (mod_cov_o),
  .fault_eff_o  (fault_eff_o)
);

// File: tb/tb_cov_monitor.sv
`timescale 1ns/1ps
module tb_cov_monitor;
  localparam int unsigned NODES = 6;
  localparam int unsigned CW    = 12;
  localparam int unsigned NCW   = $clog2(NODES + 1);
  localparam longint      WQ    = 32768;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             sample_i = 1'b0, clear_i = 1'b0, edge_mode_i = 1'b0, start_i = 1'b0;
  logic [NODES-1:0] nodes_i = '0;
  logic [CW-1:0]    det_i = '0, pot_i = '0, undet_i = '0, total_i = '0;
  logic [NCW-1:0]   covered_o, node_total_o;
  logic             busy_o, done_o, err_o;
  logic [15:0]      toggle_cov_o, mod_cov_o, fault_eff_o;

  cov_monitor #(.NODES(NODES), .CW(CW)) dut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_vec = 0;
  int n_err = 0;
  bit finished = 1'b0;

  bit m_lo[NODES], m_hi[NODES], m_rise[NODES], m_fall[NODES], m_prev[NODES];
  bit m_hv;

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_count();
    int c = 0;
    for (int i = 0; i < NODES; i++)
      if (edge_mode_i ? (m_rise[i] && m_fall[i]) : (m_lo[i] && m_hi[i])) c++;
    return c;
  endfunction

  function automatic longint ratio(input longint num, input longint den);
    longint q;
    if (den <= 0) return 0;
    q = num / den;
    return (q > 65535) ? 65535 : q;
  endfunction

  task automatic step(input bit smp, input bit clr, input logic [NODES-1:0] v);
    sample_i = smp;
    clear_i  = clr;
    nodes_i  = v;
    @(posedge clk_i);
    if (clr) begin
      for (int i = 0; i < NODES; i++) begin
        m_lo[i] = 0; m_hi[i] = 0; m_rise[i] = 0; m_fall[i] = 0; m_prev[i] = 0;
      end
      m_hv = 0;
    end else if (smp) begin
      for (int i = 0; i < NODES; i++) begin
        if (v[i]) m_hi[i] = 1; else m_lo[i] = 1;
        if (m_hv && !m_prev[i] && v[i]) m_rise[i] = 1;
        if (m_hv && m_prev[i] && !v[i]) m_fall[i] = 1;
        m_prev[i] = v[i];
      end
      m_hv = 1;
    end
    @(negedge clk_i);
    sample_i = 0;
    clear_i  = 0;
    start_i  = 0;
    chk(edge_mode_i ? "R2 covered" : "R1 covered", longint'(covered_o), longint'(model_count()));
  endtask

  // poke: issue a second start with other counts while busy (R9)
  task automatic compute(input int n, input int p, input int u, input int t, input bit poke);
    longint e_tog, e_mod, e_eff, e_err;
    bit seen;
    e_tog = ratio(longint'(model_count()) * 65536, NODES);
    e_mod = (t == 0) ? 0 : ratio(longint'(n) * 65536 + WQ * p, t);
    e_eff = (t <= u) ? 0 : ratio(longint'(n) * 65536, t - u);
    e_err = ((t == 0) || (t <= u)) ? 1 : 0;
    det_i = CW'(n); pot_i = CW'(p); undet_i = CW'(u); total_i = CW'(t);
    start_i = 1;
    step(0, 0, nodes_i);
    seen = 0;
    for (int k = 0; k < 400; k++) begin
      if (done_o) begin seen = 1; break; end
      if (poke && k == 3) begin
        det_i = 1; pot_i = 0; undet_i = 0; total_i = 1;
        start_i = 1;
      end
      step(0, 0, nodes_i);
    end
    chk("R9 done pulse seen", seen, 1);
    chk("R5 toggle ratio", toggle_cov_o, e_tog);
    chk("R6 modified coverage", mod_cov_o, e_mod);
    chk("R7 fault efficiency", fault_eff_o, e_eff);
    chk("R8 error flag", err_o, e_err);
    step(0, 0, nodes_i);
    chk("R9 done one cycle", done_o, 0);
    chk("R9 results held", toggle_cov_o, e_tog);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NODES; i++) begin
      m_lo[i] = 0; m_hi[i] = 0; m_rise[i] = 0; m_fall[i] = 0; m_prev[i] = 0;
    end
    m_hv = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R3 reset covered", covered_o, 0);
    chk("R10 node total", node_total_o, NODES);
    chk("R9 reset done", done_o, 0);
    chk("R9 reset busy", busy_o, 0);

    // level mode, partial then full
    edge_mode_i = 0;
    step(1, 0, 6'b000101);
    step(1, 0, 6'b010100);
    step(0, 0, 6'b111111);  // R4 no sample
    step(0, 0, 6'b000000);  // R4
    step(1, 0, 6'b101011);
    compute(30, 10, 20, 100, 0);
    step(1, 0, 6'b111111);
    step(1, 0, 6'b000000);
    chk("R5 level full count", covered_o, NODES);
    compute(100, 0, 0, 100, 0);

    // clear dominates a simultaneous sample
    step(1, 1, 6'b101010);
    chk("R3 clear empties", covered_o, 0);
    step(1, 0, 6'b110011);

    // edge mode: first sample after clear only loads history
    edge_mode_i = 1;
    step(0, 1, '0);
    step(1, 0, 6'b111111);
    step(1, 0, 6'b000000);
    chk("R2 load only, no rise yet", covered_o, 0);
    step(1, 0, 6'b001111);
    chk("R2 both edges on low nibble", covered_o, 4);
    step(0, 0, 6'b110000);  // R4
    step(1, 0, 6'b110000);
    step(1, 0, 6'b001100);
    compute(7, 3, 2, 9, 0);
    edge_mode_i = 0;
    step(0, 0, '0);
    compute(0, 0, 0, 0, 0);      // R8 T = 0
    compute(5, 1, 8, 8, 0);      // R8 T = U
    compute(40, 40, 0, 40, 0);   // R6 saturation
    compute(3, 2, 1, 11, 1);     // R9 start while busy ignored
    edge_mode_i = 1;
    step(1, 0, 6'b111111);
    step(1, 0, 6'b000000);
    chk("R2 edge full", covered_o, NODES);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule